// File: doc/BRIEF.md
# Branch and Call Next-PC Unit

This block works out where a single-issue 32-bit core fetches next. Each accepted request carries the current program counter, the instruction word and the values of the two source registers. The block returns the next program counter, a flag that is set when control leaves the sequential path, and a link write that puts the return address into register 29. When no transfer applies, the next address is the current one plus 4.

The instruction classes it handles are the six compare-and-branch forms, the unconditional branch, the direct call, the call through a register and the jump through a register, which includes the return form. Branches compare the two registers directly, with no condition flags. The exception-return encodings of the register-jump opcode are not resolved here. The block only reports them, so that the exception logic can act on them.

The unit has one register stage. Its behaviour is a two-state cycle. In the idle state (`out_valid` low) a request with `in_valid` high is accepted. This moves the unit to the result state, where `out_valid` is high for one cycle. From the result state the unit returns to idle if no new request arrives, or stays in the result state if a new request is present. The instruction decoder sorts each word into one transfer class: sequential, conditional branch, immediate jump, immediate call, register call, register jump or exception return.

Top module: `npc_unit`

## Requirements
- R1: After reset, and until the first accepted request, `out_valid`, `taken`, `link_we` and `xret_req` are 0 and `next_pc` is 0.
- R2: The results for a request applied with `in_valid` high appear in the following cycle with `out_valid` high. A cycle with `in_valid` low produces `out_valid` low, and `taken`, `link_we` and `xret_req` low, in the cycle after it.
- R3: The opcode is insn[31:26]. Opcodes 0x11 (equal), 0x12 (signed greater), 0x13 (signed greater-or-equal), 0x14 (unsigned greater-or-equal), 0x15 (unsigned greater) and 0x17 (not equal) compare `opa` against `opb`. When the condition holds, `taken` is 1 and `next_pc` = `cur_pc` + (sign-extended insn[15:0] shifted left by 2).
- R4: A branch whose condition fails, and every opcode not named in R3, R5, R6, R7 and R8, gives `taken` = 0, `link_we` = 0 and `next_pc` = `cur_pc` + 4.
- R5: Opcode 0x38 gives `taken` = 1 and `next_pc` = `cur_pc` + (sign-extended insn[25:0] shifted left by 2), with no link write.
- R6: Opcode 0x3e computes the same target as R5. It also sets `link_we` with `link_data` = `cur_pc` + 4.
- R7: Opcode 0x36 gives `taken` = 1 and `next_pc` = `opa`, and sets `link_we` with `link_data` = `cur_pc` + 4.
- R8: Opcode 0x30 with insn[25:21] equal to neither 0x1e nor 0x1f gives `taken` = 1 and `next_pc` = `opa`, with no link write. The return form, field 0x1d, is included.
- R9: Opcode 0x30 with insn[25:21] equal to 0x1e or 0x1f sets `xret_req`, with `xret_sel` = 0 for 0x1e and 1 for 0x1f. It gives `taken` = 0, `link_we` = 0 and `next_pc` = `cur_pc` + 4.
- R10: Whenever `link_we` is 1, `link_addr` is 29 and `taken` is 1.
- R11: All address arithmetic wraps modulo 2^32, so `cur_pc` = 0xFFFFFFFC gives a sequential address of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present this cycle |
| cur_pc | input | 32 | Program counter of the instruction |
| insn | input | 32 | Instruction word |
| opa | input | 32 | Value of the register named by insn[25:21] |
| opb | input | 32 | Value of the register named by insn[20:16] |
| out_valid | output | 1 | Result present this cycle |
| next_pc | output | 32 | Next fetch address |
| taken | output | 1 | Control leaves the sequential path |
| link_we | output | 1 | Write the return address |
| link_addr | output | 5 | Link register number (29 when writing) |
| link_data | output | 32 | Return address, `cur_pc` + 4 |
| xret_req | output | 1 | Exception-return encoding seen |
| xret_sel | output | 1 | 0: field 0x1e, 1: field 0x1f |

## Verification
The bench applies every one of the 64 opcodes with operand pairs chosen to tell signed from unsigned ordering apart:
- 0x80000000 against 0x7FFFFFFF
- all-ones against 1
- equal values
- values that differ only in the lowest bit

A comparator that mixes up signedness, or that swaps the strict and non-strict forms, therefore takes the wrong branch on at least one pair.

Negative 16-bit and 26-bit offsets catch a design that zero-extends the offset or forgets the word shift. The register-jump opcode is swept over all 32 values of its register field. This exposes a design that jumps on the exception-return codes or that refuses the 0x1d return.

Wraparound at the top of the address space and idle cycles between requests show up any carry that leaks out of the adder, and any link or request flag that stays set.

// File: rtl/npc_pkg.sv
package npc_pkg;

    localparam int unsigned OPC_W = 6;

    localparam logic [OPC_W-1:0] OP_BEQ   = 6'h11;
    localparam logic [OPC_W-1:0] OP_BGT   = 6'h12;
    localparam logic [OPC_W-1:0] OP_BGE   = 6'h13;
    localparam logic [OPC_W-1:0] OP_BGEU  = 6'h14;
    localparam logic [OPC_W-1:0] OP_BGTU  = 6'h15;
    localparam logic [OPC_W-1:0] OP_BNE   = 6'h17;
    localparam logic [OPC_W-1:0] OP_JIMM  = 6'h38;
    localparam logic [OPC_W-1:0] OP_CIMM  = 6'h3e;
    localparam logic [OPC_W-1:0] OP_CREG  = 6'h36;
    localparam logic [OPC_W-1:0] OP_JREG  = 6'h30;

    localparam logic [4:0] XRET_FIELD_A = 5'h1e;
    localparam logic [4:0] XRET_FIELD_B = 5'h1f;

    typedef enum logic [2:0] {
        XK_SEQ,
        XK_BRANCH,
        XK_JUMP_IMM,
        XK_CALL_IMM,
        XK_CALL_REG,
        XK_JUMP_REG,
        XK_XRET
    } xfer_kind_e;

    typedef enum logic [2:0] {
        CMP_EQ,
        CMP_NE,
        CMP_GT,
        CMP_GE,
        CMP_GTU,
        CMP_GEU
    } cmp_op_e;

endpackage

// File: rtl/npc_decode.sv
module npc_decode
    import npc_pkg::*;
(
    input  logic [31:0] insn,
    output xfer_kind_e  kind,
    output cmp_op_e     cmp_op,
    output logic        xret_sel
);
    logic [OPC_W-1:0] opc;
    logic [4:0]       src_field;

    assign opc       = insn[31:26];
    assign src_field = insn[25:21];
    assign xret_sel  = (src_field == XRET_FIELD_B);

    always_comb begin
        kind   = XK_SEQ;
        cmp_op = CMP_EQ;
        unique case (opc)
            OP_BEQ:  begin kind = XK_BRANCH; cmp_op = CMP_EQ;  end
            OP_BNE:  begin kind = XK_BRANCH; cmp_op = CMP_NE;  end
            OP_BGT:  begin kind = XK_BRANCH; cmp_op = CMP_GT;  end
            OP_BGE:  begin kind = XK_BRANCH; cmp_op = CMP_GE;  end
            OP_BGTU: begin kind = XK_BRANCH; cmp_op = CMP_GTU; end
            OP_BGEU: begin kind = XK_BRANCH; cmp_op = CMP_GEU; end
            OP_JIMM: kind = XK_JUMP_IMM;
            OP_CIMM: kind = XK_CALL_IMM;
            OP_CREG: kind = XK_CALL_REG;
            OP_JREG: begin
                if (src_field == XRET_FIELD_A || src_field == XRET_FIELD_B)
                    kind = XK_XRET;
                else
                    kind = XK_JUMP_REG;
            end
            default: kind = XK_SEQ;
        endcase
    end
endmodule

// File: rtl/npc_compare.sv
module npc_compare
    import npc_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  logic [XLEN-1:0] lhs,
    input  logic [XLEN-1:0] rhs,
    input  cmp_op_e         op,
    output logic            hit
);
    logic eq_w, sgt_w, ugt_w;

    assign eq_w  = (lhs == rhs);
    assign sgt_w = ($signed(lhs) > $signed(rhs));
    assign ugt_w = (lhs > rhs);

    always_comb begin
        unique case (op)
            CMP_EQ:  hit = eq_w;
            CMP_NE:  hit = !eq_w;
            CMP_GT:  hit = sgt_w;
            CMP_GE:  hit = sgt_w || eq_w;
            CMP_GTU: hit = ugt_w;
            CMP_GEU: hit = ugt_w || eq_w;
            default: hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/npc_target.sv
module npc_target #(
    parameter int unsigned XLEN    = 32,
    parameter int unsigned SHORT_W = 16,
    parameter int unsigned LONG_W  = 26,
    parameter int unsigned STEP    = 4
) (
    input  logic [XLEN-1:0] pc,
    input  logic [31:0]     insn,
    output logic [XLEN-1:0] seq_pc,
    output logic [XLEN-1:0] short_tgt,
    output logic [XLEN-1:0] long_tgt
);
    localparam int unsigned SHAMT = $clog2(STEP);

    logic [XLEN-1:0] short_off, long_off;

    generate
        if (XLEN > SHORT_W + SHAMT) begin : g_short_ext
            assign short_off = {{(XLEN-SHORT_W-SHAMT){insn[SHORT_W-1]}},
                                insn[SHORT_W-1:0], {SHAMT{1'b0}}};
        end else begin : g_short_cut
            assign short_off = XLEN'({insn[SHORT_W-1:0], {SHAMT{1'b0}}});
        end
        if (XLEN > LONG_W + SHAMT) begin : g_long_ext
            assign long_off = {{(XLEN-LONG_W-SHAMT){insn[LONG_W-1]}},
                               insn[LONG_W-1:0], {SHAMT{1'b0}}};
        end else begin : g_long_cut
            assign long_off = XLEN'({insn[LONG_W-1:0], {SHAMT{1'b0}}});
        end
    endgenerate

    assign seq_pc    = pc + XLEN'(STEP);
    assign short_tgt = pc + short_off;
    assign long_tgt  = pc + long_off;
endmodule

// File: rtl/npc_unit.sv
module npc_unit
    import npc_pkg::*;
#(
    parameter int unsigned XLEN     = 32,
    parameter int unsigned LINK_REG = 29
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [XLEN-1:0] cur_pc,
    input  logic [31:0]     insn,
    input  logic [XLEN-1:0] opa,
    input  logic [XLEN-1:0] opb,
    output logic            out_valid,
    output logic [XLEN-1:0] next_pc,
    output logic            taken,
    output logic            link_we,
    output logic [4:0]      link_addr,
    output logic [XLEN-1:0] link_data,
    output logic            xret_req,
    output logic            xret_sel
);
    typedef enum logic {ST_IDLE, ST_RESULT} st_e;

    st_e             st_q, st_d;
    xfer_kind_e      kind;
    cmp_op_e         cmp_op;
    logic            cmp_hit, sel_c;
    logic [XLEN-1:0] seq_pc, short_tgt, long_tgt;
    logic [XLEN-1:0] npc_c;
    logic            taken_c, link_c, xret_c;

    npc_decode u_dec (
        .insn(insn), .kind(kind), .cmp_op(cmp_op), .xret_sel(sel_c)
    );

    npc_compare #(.XLEN(XLEN)) u_cmp (
        .lhs(opa), .rhs(opb), .op(cmp_op), .hit(cmp_hit)
    );

    npc_target #(.XLEN(XLEN)) u_tgt (
        .pc(cur_pc), .insn(insn), .seq_pc(seq_pc),
        .short_tgt(short_tgt), .long_tgt(long_tgt)
    );

    always_comb begin
        npc_c   = seq_pc;
        taken_c = 1'b0;
        link_c  = 1'b0;
        xret_c  = 1'b0;
        unique case (kind)
            XK_BRANCH: begin
                if (cmp_hit) begin
                    npc_c   = short_tgt;
                    taken_c = 1'b1;
                end
            end
            XK_JUMP_IMM: begin npc_c = long_tgt; taken_c = 1'b1; end
            XK_CALL_IMM: begin npc_c = long_tgt; taken_c = 1'b1; link_c = 1'b1; end
            XK_CALL_REG: begin npc_c = opa;      taken_c = 1'b1; link_c = 1'b1; end
            XK_JUMP_REG: begin npc_c = opa;      taken_c = 1'b1; end
            XK_XRET:     xret_c = 1'b1;
            default:     npc_c = seq_pc;
        endcase
    end

    always_comb begin
        unique case (st_q)
            ST_IDLE:   st_d = in_valid ? ST_RESULT : ST_IDLE;
            ST_RESULT: st_d = in_valid ? ST_RESULT : ST_IDLE;
            default:   st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            next_pc   <= '0;
            taken     <= 1'b0;
            link_we   <= 1'b0;
            link_addr <= '0;
            link_data <= '0;
            xret_req  <= 1'b0;
            xret_sel  <= 1'b0;
        end else if (in_valid) begin
            next_pc   <= npc_c;
            taken     <= taken_c;
            link_we   <= link_c;
            link_addr <= link_c ? 5'(LINK_REG) : 5'd0;
            link_data <= seq_pc;
            xret_req  <= xret_c;
            xret_sel  <= xret_c & sel_c;
        end else begin
            taken     <= 1'b0;
            link_we   <= 1'b0;
            link_addr <= '0;
            xret_req  <= 1'b0;
            xret_sel  <= 1'b0;
        end
    end

    assign out_valid = (st_q == ST_RESULT);

    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r2_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid && !taken && !link_we && !xret_req);
    a_r1_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> !taken && !link_we && !xret_req);
    a_r10_link_target: assert property (@(posedge clk) disable iff (!rst_n)
        link_we |-> (link_addr == 5'(LINK_REG)) && taken);
    a_r9_xret_no_jump: assert property (@(posedge clk) disable iff (!rst_n)
        xret_req |-> !taken && !link_we && (next_pc == link_data));
    a_r4_seq_address: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !taken) |-> (next_pc == link_data));
endmodule

// File: tb/npc_unit_bench.sv
module npc_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] cur_pc = '0, insn = '0, opa = '0, opb = '0;
    logic        out_valid, taken, link_we, xret_req, xret_sel;
    logic [31:0] next_pc, link_data;
    logic [4:0]  link_addr;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    npc_unit u_npc_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .cur_pc(cur_pc),
        .insn(insn), .opa(opa), .opb(opb), .out_valid(out_valid),
        .next_pc(next_pc), .taken(taken), .link_we(link_we),
        .link_addr(link_addr), .link_data(link_data),
        .xret_req(xret_req), .xret_sel(xret_sel)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic run_one(input logic [31:0] pc, input logic [31:0] w,
                           input logic [31:0] a, input logic [31:0] b);
        logic [5:0]  op;
        logic [4:0]  rs;
        logic [31:0] seq, nxt, off16, off26;
        logic        tk, lw, xr, xs, cond;
        string       tag;
        op    = w[31:26];
        rs    = w[25:21];
        seq   = pc + 32'd4;
        off16 = {{14{w[15]}}, w[15:0], 2'b00};
        off26 = {{4{w[25]}}, w[25:0], 2'b00};
        nxt = seq; tk = 0; lw = 0; xr = 0; xs = 0; cond = 0; tag = "R4";
        case (op)
            6'h11, 6'h12, 6'h13, 6'h14, 6'h15, 6'h17: begin
                case (op)
                    6'h11: cond = (a == b);
                    6'h12: cond = ($signed(a) > $signed(b));
                    6'h13: cond = ($signed(a) >= $signed(b));
                    6'h14: cond = (a >= b);
                    6'h15: cond = (a > b);
                    default: cond = (a != b);
                endcase
                if (cond) begin tag = "R3"; nxt = pc + off16; tk = 1; end
                else tag = "R4";
            end
            6'h38: begin tag = "R5"; nxt = pc + off26; tk = 1; end
            6'h3e: begin tag = "R6"; nxt = pc + off26; tk = 1; lw = 1; end
            6'h36: begin tag = "R7"; nxt = a; tk = 1; lw = 1; end
            6'h30: begin
                if (rs == 5'h1e || rs == 5'h1f) begin
                    tag = "R9"; xr = 1; xs = (rs == 5'h1f);
                end else begin
                    tag = "R8"; nxt = a; tk = 1;
                end
            end
            default: tag = "R4";
        endcase
        @(negedge clk);
        cur_pc = pc; insn = w; opa = a; opb = b; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R2", "out_valid", 32'(out_valid), 32'd1);
        chk(tag, "next_pc", next_pc, nxt);
        chk(tag, "taken", 32'(taken), 32'(tk));
        chk(tag, "link_we", 32'(link_we), 32'(lw));
        chk(tag, "xret_req", 32'(xret_req), 32'(xr));
        if (xr) chk("R9", "xret_sel", 32'(xret_sel), 32'(xs));
        if (lw) begin
            chk("R10", "link_addr", 32'(link_addr), 32'd29);
            chk(tag, "link_data", link_data, seq);
        end
    endtask

    function automatic logic [63:0] pair_of(input int k);
        case (k)
            0: return {32'd5, 32'd5};
            1: return {32'd5, 32'd7};
            2: return {32'd7, 32'd5};
            3: return {32'hFFFF_FFFF, 32'd1};
            4: return {32'd1, 32'hFFFF_FFFF};
            5: return {32'h8000_0000, 32'h7FFF_FFFF};
            6: return {32'h7FFF_FFFF, 32'h8000_0000};
            default: return {32'h1234_5678, 32'h1234_5679};
        endcase
    endfunction

    initial begin
        #2_000_000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "out_valid", 32'(out_valid), 32'd0);
        chk("R1", "taken", 32'(taken), 32'd0);
        chk("R1", "link_we", 32'(link_we), 32'd0);
        chk("R1", "xret_req", 32'(xret_req), 32'd0);
        chk("R1", "next_pc", next_pc, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "out_valid after release", 32'(out_valid), 32'd0);

        for (int op = 0; op < 64; op++) begin
            for (int k = 0; k < 8; k++) begin
                logic [63:0] p;
                logic [15:0] low;
                logic [31:0] w;
                p   = pair_of(k);
                low = k[0] ? 16'h8003 : 16'h0123;
                w   = {6'(op), 5'(k * 3 + 1), 5'(k), low};
                run_one(32'h0004_0000 + 32'(op * 256), w, p[63:32], p[31:0]);
            end
        end

        // R8 / R9: register jump over every value of the register field
        for (int f = 0; f < 32; f++) begin
            run_one(32'h0000_2000, {6'h30, 5'(f), 21'd0}, 32'h0000_ABC0, 32'd0);
        end

        // R11: wraparound of the sequential and target arithmetic
        run_one(32'hFFFF_FFFC, 32'h0000_0000, 32'd0, 32'd0);
        run_one(32'hFFFF_FFFC, {6'h3e, 26'h000_0004}, 32'd0, 32'd0);
        run_one(32'h0000_0004, {6'h38, 26'h3FF_FFFE}, 32'd0, 32'd0);
        chk("R11", "wrapped target", next_pc, 32'hFFFF_FFFC);

        // R2: idle cycle clears the result flags
        run_one(32'h100, {6'h36, 26'd0}, 32'h0000_0800, 32'd0);
        @(negedge clk);
        chk("R2", "out_valid idle", 32'(out_valid), 32'd0);
        chk("R2", "taken idle", 32'(taken), 32'd0);
        chk("R2", "link_we idle", 32'(link_we), 32'd0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule